// File: doc/BRIEF.md
# Dual-Rectifier Carrier PWM Modulator

This block generates the gate commands for two single-phase rectifier bridges that share one DC link and one grid connection. Each bridge has two legs, so four legs are driven in total. The control loop supplies three signed voltage demands: the differential voltage of bridge A, the differential voltage of bridge B, and the voltage that drives the circulating current between the bridges. Four leg voltages carry three demands, so one degree of freedom remains. The block resolves it with an offset term. The offset is kept inside the window that the DC-link voltage allows, and a blend factor places it within that window.

Each leg voltage is limited to plus or minus half the DC link. It is then compared with a triangular carrier to set the leg's upper and lower gates. With one carrier, all four legs share it. With two carriers, bridge B uses the mirror image of the first triangle, which is shifted by half a period. All demands are sampled once per carrier cycle, at the carrier peak, so each half-period runs on one consistent set of values.

Top module: `pwm2r_modulator`

## Requirements
- R1: The bridge-A leg references are A1 = a + x and A2 = x. Here a is the bridge-A demand and x is the offset. Gate bit order on both gate buses is {B2, B1, A2, A1}, with bit 0 = A1.
- R2: The bridge-B leg references are B1 = (a + b - c)/2 + x and B2 = (a - b - c)/2 + x. Here b is the bridge-B demand and c is the circulating demand. These give A1-A2 = a, B1-B2 = b and A1+A2-B1-B2 = c.
- R3: Let V be the DC-link input, so half the link is V/2. Let m be the largest and n the smallest of the offset-free terms {a, 0, (a+b-c)/2, (a-b-c)/2}. The offset is x = u*(V/2 - m) + (1-u)*(-V/2 - n), where u = mu/256. In doubled units, the blended sum is divided by 256 with floor rounding. Any mu value above 256 acts as 256.
- R4: Each leg reference is clamped to the range -V/2 to +V/2 before it is compared.
- R5: Carrier 1 is a counter k that starts at 0 after reset, counts up by one per clock to the period P, then counts down to 0, and repeats. P is sampled from the period input whenever k is 0. A period input of 0 acts as 1.
- R6: A leg's upper gate is on when its reference is strictly greater than the carrier value -V/2 + k*V/P. The lower gate is on otherwise. Gates are registered, so they show the result for the counter value of the previous clock.
- R7: When car_mode is 0 (single carrier), all legs use k. When car_mode is 1 (double carrier), the bridge-B legs use P - k, which is the triangle shifted by 180 degrees.
- R8: The demands, mu, car_mode and V are captured only on the clock where k equals P. Changes at any other time do not affect the gates until the next peak.
- R9: While en is high, exactly one gate of each leg is on. One clock after en is low, all eight gates are low.
- R10: During reset all gates are low, and the captured demands, mu, mode and V are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Gate enable; when low, all gates are forced off |
| car_mode | input | 1 | 0 = single carrier, 1 = double carrier |
| period | input | PERW | Carrier half-period in clocks |
| vdc_ref | input | DW | DC-link voltage V, unsigned |
| ref_a | input | DW | Bridge-A differential demand, signed |
| ref_b | input | DW | Bridge-B differential demand, signed |
| ref_circ | input | DW | Circulating-current voltage demand, signed |
| mu | input | MUW+1 | Offset blend factor, 256 = 1.0 |
| gate_hi | output | 4 | Upper gates {B2, B1, A2, A1} |
| gate_lo | output | 4 | Lower gates {B2, B1, A2, A1} |

## Verification
The bench builds the block with its default widths: 16-bit voltages, a 16-bit period and an 8-bit blend fraction. This keeps the full demand range available, so the clamp and the offset window can be pushed to their edges with a small link voltage. Periods of 0, 1, 5, 7, 8 and 20 are used. These cover the degenerate triangle, an odd period where the mirrored carrier never meets the first one, and a period long enough to resolve pulse placement for mu at 0, 256 and above 256. The demands also change between peaks, which shows that the sampling at the peak holds.

// File: rtl/pwm2r_pkg.sv
// Package: shared types and constants for the dual-rectifier modulator.
// Assumes four legs in the fixed order A1, A2, B1, B2.
package pwm2r_pkg;
    localparam int NPOLE = 4;
    localparam int LEG_A1 = 0;
    localparam int LEG_A2 = 1;
    localparam int LEG_B1 = 2;
    localparam int LEG_B2 = 3;

    typedef enum logic {
        CAR_SINGLE = 1'b0,
        CAR_DOUBLE = 1'b1
    } car_mode_e;
endpackage

// File: rtl/pwm2r_carrier.sv
// Module: up/down triangle carrier with a mirrored companion.
// The counter runs 0..P..0. P is sampled at the valley, and a period of 0
// is taken as 1. The mirror output is P - k, the triangle shifted by half
// a period. peak is high on the clock where the counter equals P.
module pwm2r_carrier #(
    parameter int PERW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PERW-1:0] per_in,
    output logic [PERW-1:0] cnt,
    output logic [PERW-1:0] cnt_mir,
    output logic [PERW-1:0] per_q,
    output logic            peak
);
    logic            dn;
    logic [PERW-1:0] per_eff;

    // Period in force for this step: newly sampled at the valley
    always_comb begin
        if (cnt == '0) begin
            per_eff = (per_in == '0) ? PERW'(1) : per_in;
        end else begin
            per_eff = per_q;
        end
    end

    // Triangle counter and direction flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            dn    <= 1'b0;
            per_q <= PERW'(1);
        end else begin
            per_q <= per_eff;
            if (!dn) begin
                cnt <= cnt + 1'b1;
                if (cnt + 1'b1 == per_eff) begin
                    dn <= 1'b1;
                end
            end else begin
                cnt <= cnt - 1'b1;
                if (cnt == PERW'(1)) begin
                    dn <= 1'b0;
                end
            end
        end
    end

    // Mirrored carrier and peak strobe
    assign cnt_mir = per_q - cnt;
    assign peak    = (cnt == per_q) && (cnt != '0);
endmodule

// File: rtl/pwm2r_pole_calc.sv
// Module: maps three demands onto four leg references through a free offset.
// All internal math is in doubled units, so halving the bridge-B terms
// loses nothing. The offset lies between the window limits set by the
// link voltage and is placed by mu (256 = 1.0, larger values saturate).
// Outputs are in doubled units and clamped to +/- vdc.
module pwm2r_pole_calc
    import pwm2r_pkg::*;
#(
    parameter int DW  = 16,
    parameter int MUW = 8
) (
    input  logic signed [DW-1:0]              ref_a,
    input  logic signed [DW-1:0]              ref_b,
    input  logic signed [DW-1:0]              ref_c,
    input  logic        [DW-1:0]              vdc,
    input  logic        [MUW:0]               mu,
    output logic        [NPOLE-1:0][DW+1:0]   pole
);
    localparam int TW = DW + 3;
    localparam int XW = TW + MUW + 2;
    localparam int PLW = DW + 2;
    localparam logic [MUW:0] MU_ONE = {1'b1, {MUW{1'b0}}};

    logic signed [TW-1:0] sa, sb, sc, vv;
    logic signed [TW-1:0] t [NPOLE];
    logic signed [TW-1:0] t_max, t_min, x_hi, x_lo, x_off;
    logic        [MUW:0]  mu_s;
    logic signed [XW-1:0] hi_x, lo_x, mu_x, nu_x, blend;

    // Widen inputs to the working width
    always_comb begin
        sa = {{3{ref_a[DW-1]}}, ref_a};
        sb = {{3{ref_b[DW-1]}}, ref_b};
        sc = {{3{ref_c[DW-1]}}, ref_c};
        vv = $signed({3'b000, vdc});
    end

    // Offset-free leg terms in doubled units
    always_comb begin
        t[LEG_A1] = sa <<< 1;
        t[LEG_A2] = '0;
        t[LEG_B1] = sa + sb - sc;
        t[LEG_B2] = sa - sb - sc;
    end

    // Extremes of the offset-free terms
    always_comb begin
        t_max = t[0];
        t_min = t[0];
        for (int i = 1; i < NPOLE; i++) begin
            if (t[i] > t_max) t_max = t[i];
            if (t[i] < t_min) t_min = t[i];
        end
    end

    // Window limits for the offset
    assign x_hi = vv - t_max;
    assign x_lo = -vv - t_min;

    // Saturate mu to 1.0
    assign mu_s = (mu > MU_ONE) ? MU_ONE : mu;

    // Blend the two limits with mu and drop the fraction (floor)
    always_comb begin
        hi_x  = XW'(x_hi);
        lo_x  = XW'(x_lo);
        mu_x  = $signed({{(XW-MUW-1){1'b0}}, mu_s});
        nu_x  = $signed({{(XW-MUW-1){1'b0}}, MU_ONE - mu_s});
        blend = hi_x * mu_x + lo_x * nu_x;
        x_off = TW'(blend >>> MUW);
    end

    // Add the offset to each leg and clamp to the link
    always_comb begin
        for (int i = 0; i < NPOLE; i++) begin
            logic signed [TW-1:0] full;
            full = t[i] + x_off;
            if (full > vv) begin
                pole[i] = PLW'(vv);
            end else if (full < -vv) begin
                pole[i] = PLW'(-vv);
            end else begin
                pole[i] = PLW'(full);
            end
        end
    end
endmodule

// File: rtl/pwm2r_leg_cmp.sv
// Module: one leg comparator with complementary registered gates.
// The reference is in doubled units within +/- vdc. The carrier value is
// -vdc + 2*vdc*cnt/per in the same units. Both sides are cross-multiplied,
// so no division is needed. Both gates are forced low while en is low.
module pwm2r_leg_cmp #(
    parameter int DW   = 16,
    parameter int PERW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW+1:0] pole,
    input  logic        [DW-1:0] vdc,
    input  logic      [PERW-1:0] cnt,
    input  logic      [PERW-1:0] per,
    output logic                 g_hi,
    output logic                 g_lo
);
    localparam int MW = DW + 3 + PERW;

    logic signed [DW+2:0] shifted;
    logic        [MW-1:0] lhs, rhs;
    logic                 on;

    // Reference moved to the 0..2*vdc range
    assign shifted = {pole[DW+1], pole} + $signed({3'b000, vdc});

    // Cross-multiplied comparison against the carrier
    always_comb begin
        lhs = MW'($unsigned(shifted)) * MW'(per);
        rhs = MW'(cnt) * MW'({vdc, 1'b0});
        on  = lhs > rhs;
    end

    // Registered complementary gates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_hi <= 1'b0;
            g_lo <= 1'b0;
        end else begin
            g_hi <= en & on;
            g_lo <= en & ~on;
        end
    end
endmodule

// File: rtl/pwm2r_modulator.sv
// Module: top of the dual-rectifier carrier modulator.
// Samples the demands at the carrier peak, spreads them onto four legs and
// drives complementary gate pairs. In double-carrier mode the bridge-B legs
// compare against the mirrored triangle.
module pwm2r_modulator
    import pwm2r_pkg::*;
#(
    parameter int DW   = 16,
    parameter int PERW = 16,
    parameter int MUW  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 car_mode,
    input  logic      [PERW-1:0] period,
    input  logic        [DW-1:0] vdc_ref,
    input  logic signed [DW-1:0] ref_a,
    input  logic signed [DW-1:0] ref_b,
    input  logic signed [DW-1:0] ref_circ,
    input  logic         [MUW:0] mu,
    output logic     [NPOLE-1:0] gate_hi,
    output logic     [NPOLE-1:0] gate_lo
);
    logic [PERW-1:0] cnt, cnt_mir, per_q;
    logic            peak;

    logic signed [DW-1:0] a_q, b_q, c_q;
    logic        [DW-1:0] vdc_q;
    logic        [MUW:0]  mu_q;
    car_mode_e            mode_q;

    logic [NPOLE-1:0][DW+1:0] pole;

    // Carrier generation
    pwm2r_carrier #(.PERW(PERW)) u_car (
        .clk    (clk),
        .rst_n  (rst_n),
        .per_in (period),
        .cnt    (cnt),
        .cnt_mir(cnt_mir),
        .per_q  (per_q),
        .peak   (peak)
    );

    // Capture the demands at the carrier peak only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            c_q    <= '0;
            vdc_q  <= '0;
            mu_q   <= '0;
            mode_q <= CAR_SINGLE;
        end else if (peak) begin
            a_q    <= ref_a;
            b_q    <= ref_b;
            c_q    <= ref_circ;
            vdc_q  <= vdc_ref;
            mu_q   <= mu;
            mode_q <= car_mode_e'(car_mode);
        end
    end

    // Leg reference computation
    pwm2r_pole_calc #(.DW(DW), .MUW(MUW)) u_calc (
        .ref_a(a_q),
        .ref_b(b_q),
        .ref_c(c_q),
        .vdc  (vdc_q),
        .mu   (mu_q),
        .pole (pole)
    );

    // One comparator per leg; bridge B may use the mirrored carrier
    for (genvar i = 0; i < NPOLE; i++) begin : g_leg
        localparam bit ON_B = (i >= LEG_B1);
        logic [PERW-1:0] c_sel;

        assign c_sel = (ON_B && mode_q == CAR_DOUBLE) ? cnt_mir : cnt;

        pwm2r_leg_cmp #(.DW(DW), .PERW(PERW)) u_leg (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (en),
            .pole (pole[i]),
            .vdc  (vdc_q),
            .cnt  (c_sel),
            .per  (per_q),
            .g_hi (gate_hi[i]),
            .g_lo (gate_lo[i])
        );
    end
endmodule

// File: rtl/pwm2r_checker.sv
// Module: property checker bound to the modulator top.
// Observes the gates, the carrier counter and one captured demand.
module pwm2r_checker #(
    parameter int DW   = 16,
    parameter int PERW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic [3:0]      gate_hi,
    input logic [3:0]      gate_lo,
    input logic [PERW-1:0] cnt,
    input logic [PERW-1:0] per_q,
    input logic            peak,
    input logic [DW-1:0]   a_q
);
    // R9: the two gates of a leg are never on together
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == 4'h0);

    // R9: a low enable turns every gate off on the next clock
    p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (gate_hi == 4'h0 && gate_lo == 4'h0));

    // R9: a high enable turns exactly one gate of each leg on
    p_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((gate_hi ^ gate_lo) == 4'hF));

    // R5: the counter stays within the period
    p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= per_q);

    // R5: the counter moves by exactly one each clock
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cnt == $past(cnt) + 1'b1) || (cnt + 1'b1 == $past(cnt))));

    // R8: a captured demand holds away from the peak
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !peak |=> $stable(a_q));
endmodule

bind pwm2r_modulator pwm2r_checker #(.DW(DW), .PERW(PERW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .gate_hi(gate_hi),
    .gate_lo(gate_lo),
    .cnt    (cnt),
    .per_q  (per_q),
    .peak   (peak),
    .a_q    (a_q)
);

// File: tb/pwm2r_modulator_test.sv
// Bench: behavioural reference model compared with the gates on every clock.
module pwm2r_modulator_test;
    localparam int DW = 16;
    localparam int PERW = 16;
    localparam int MUW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic car_mode = 1'b0;
    logic [PERW-1:0] period = 16'd8;
    logic [DW-1:0] vdc_ref = '0;
    logic signed [DW-1:0] ref_a = '0, ref_b = '0, ref_circ = '0;
    logic [MUW:0] mu = '0;
    logic [3:0] gate_hi, gate_lo;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R10";

    always #5 clk = ~clk;

    pwm2r_modulator #(.DW(DW), .PERW(PERW), .MUW(MUW)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .car_mode(car_mode),
        .period(period), .vdc_ref(vdc_ref), .ref_a(ref_a), .ref_b(ref_b),
        .ref_circ(ref_circ), .mu(mu), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    // Model state
    longint m_cnt, m_per, m_va, m_vb, m_vc, m_vdc, m_mu;
    bit m_dn, m_mode;
    logic [3:0] m_hi, m_lo;

    // Upper-gate decision per leg from the requirements (doubled units)
    function automatic logic [3:0] leg_on(longint k, longint p, longint a,
                                          longint b, longint c, longint v,
                                          longint u, bit dbl);
        longint t[4];
        longint mx, mn, xo, uu, pl, kk;
        logic [3:0] r;
        t[0] = 2 * a; t[1] = 0; t[2] = a + b - c; t[3] = a - b - c;
        mx = t[0]; mn = t[0];
        foreach (t[i]) begin
            if (t[i] > mx) mx = t[i];
            if (t[i] < mn) mn = t[i];
        end
        uu = (u > 256) ? 256 : u;
        xo = ((v - mx) * uu + (-v - mn) * (256 - uu)) >>> 8;
        for (int i = 0; i < 4; i++) begin
            pl = t[i] + xo;
            if (pl > v) pl = v;
            if (pl < -v) pl = -v;
            kk = (i >= 2 && dbl) ? (p - k) : k;
            r[i] = ((pl + v) * p) > (kk * 2 * v);
        end
        return r;
    endfunction

    // Reference model, one step per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_dn = 0; m_per = 1;
            m_va = 0; m_vb = 0; m_vc = 0; m_vdc = 0; m_mu = 0; m_mode = 0;
            m_hi = 4'h0; m_lo = 4'h0;
        end else begin
            logic [3:0] on;
            longint eff;
            on = leg_on(m_cnt, m_per, m_va, m_vb, m_vc, m_vdc, m_mu, m_mode);
            m_hi = en ? on : 4'h0;
            m_lo = en ? ~on : 4'h0;
            if (m_cnt == m_per && m_cnt != 0) begin
                m_va = longint'(ref_a); m_vb = longint'(ref_b);
                m_vc = longint'(ref_circ); m_vdc = longint'(vdc_ref);
                m_mu = longint'(mu); m_mode = car_mode;
            end
            eff = (m_cnt == 0) ? ((period == 0) ? 1 : longint'(period)) : m_per;
            m_per = eff;
            if (!m_dn) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == eff) m_dn = 1;
            end else begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) m_dn = 0;
            end
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (gate_hi !== m_hi || gate_lo !== m_lo) begin
                errors++;
                $display("FAIL %s gates hi=%b lo=%b expected hi=%b lo=%b",
                         cur_req, gate_hi, gate_lo, m_hi, m_lo);
            end
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_refs(int a, int b, int c, int v, int u, bit dbl);
        ref_a = DW'(a); ref_b = DW'(b); ref_circ = DW'(c);
        vdc_ref = DW'(v); mu = (MUW+1)'(u); car_mode = dbl;
    endtask

    // Stimulus
    initial begin
        int seed;
        run(4);
        // R10: gates low in reset
        checks++;
        if (gate_hi !== 4'h0 || gate_lo !== 4'h0) begin
            errors++;
            $display("FAIL R10 reset gates hi=%b lo=%b expected 0000", gate_hi, gate_lo);
        end
        rst_n = 1'b1;
        cur_req = "R9";
        run(20);
        cur_req = "R5";
        en = 1'b1;
        set_refs(0, 0, 0, 20000, 128, 0);
        run(40);
        cur_req = "R1";
        set_refs(8000, 0, 0, 20000, 128, 0);
        run(60);
        cur_req = "R2";
        set_refs(4000, 5000, -3000, 20000, 128, 1);
        run(60);
        cur_req = "R7";
        period = 16'd20;
        run(100);
        car_mode = 1'b0;
        run(100);
        cur_req = "R3";
        set_refs(6000, -2000, 1000, 24000, 0, 1);
        run(90);
        mu = 9'd256;
        run(90);
        mu = 9'd400;
        run(90);
        mu = 9'd77;
        run(90);
        cur_req = "R4";
        period = 16'd8;
        set_refs(30000, -30000, 20000, 10000, 200, 0);
        run(60);
        set_refs(-32768, 32767, -32768, 65535, 30, 1);
        run(60);
        cur_req = "R5";
        set_refs(3000, 1000, 500, 16000, 128, 1);
        period = 16'd5;
        run(50);
        period = 16'd1;
        run(20);
        period = 16'd0;
        run(20);
        cur_req = "R8";
        period = 16'd7;
        seed = 12345;
        for (int i = 0; i < 40; i++) begin
            seed = seed * 1103515245 + 12345;
            set_refs((seed >>> 8) % 12000, (seed >>> 4) % 9000,
                     (seed >>> 12) % 7000, 30000, (seed >>> 3) & 511, seed[20]);
            run(3);
        end
        cur_req = "R6";
        period = 16'd20;
        set_refs(-5000, 7000, 2500, 18000, 180, 0);
        run(100);
        cur_req = "R9";
        for (int i = 0; i < 6; i++) begin
            en = ~en;
            run(7);
        end
        en = 1'b0;
        run(5);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog run hung actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule